// File: doc/BRIEF.md
# Three-Pass Subranging Conversion Sequencer

This block is the digital half of a subranging flash converter. A single bank of 15 comparators is reused three times. In each pass the block waits a fixed number of clocks for the comparators to settle. It then reduces their thermometer vector to a 4-bit count and uses that nibble to narrow the reference window for the next pass. After the third pass the 12-bit word is placed in an output register, and a one-cycle completion pulse marks the update.

The block drives two outputs that steer the analog side. `seg_sel_o` carries the nibbles resolved so far, packed from the top bit down with zeros below them. `pass_o` gives the index of the current pass. From these two values the analog side, or a model of it, can derive every comparator threshold. Two flags report misuse. One is set when a pass returns a comparator pattern that is not a clean thermometer code. The other is set when a start request arrives while a conversion is running.

Top module: `subrange_seq`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, `done_o`, `result_o`, `pass_o`, `seg_sel_o`, `bubble_err_o` and `overrun_o` are all zero.
- R2: When `start_i` is high on a rising edge while the block is idle, a conversion begins. `done_o` rises exactly 3*SETTLE edges after that accepting edge, where SETTLE defaults to 4, and it stays high for one cycle only.
- R3: During a conversion `pass_o` reads 0, 1 and 2 in turn, and each value holds for SETTLE cycles. `seg_sel_o` is 0x00 in pass 0. In pass 1 it is {first nibble, 4'b0000}. In pass 2 it is {first nibble, second nibble}. It does not change within a pass.
- R4: Each pass samples `cmp_i` on its last settle cycle. Bit k-1 of `cmp_i` stands for the k-th threshold of the current window. The nibble for that pass is the number of asserted bits, from 0 to 15.
- R5: `result_o` is natural binary with its MSB in bit 11. The pass-0 nibble goes to bits [11:8], the pass-1 nibble to bits [7:4] and the pass-2 nibble to bits [3:0]. An ideal input of code 0x000 reads back as 0x000, and 0xFFF reads back as 0xFFF.
- R6: When the code is read as offset binary, the two codes on either side of midscale, 0x7FF and 0x800, are each resolved exactly.
- R7: `result_o` changes only on the edge that raises `done_o`. It holds the previous word for the whole of a conversion and afterwards.
- R8: If a pass sees a pattern where a higher comparator is set above a cleared lower one, its nibble is still the count of set bits. `bubble_err_o` is then set and stays set until the next accepted start clears it.
- R9: A start request that arrives during a conversion does not change the timing or the result of that conversion. It sets `overrun_o`, which stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, sampled on each rising edge |
| cmp_i | input | 15 | Comparator outputs; bit k-1 is the k-th threshold of the current window |
| seg_sel_o | output | 8 | Nibbles resolved so far, packed from the top, selecting the reference window |
| pass_o | output | 2 | Index of the current pass |
| done_o | output | 1 | One-cycle pulse when a new result is loaded |
| result_o | output | 12 | Last completed conversion word, MSB in bit 11 |
| bubble_err_o | output | 1 | Sticky flag: a pass saw a non-thermometer comparator pattern |
| overrun_o | output | 1 | Sticky flag: a start request arrived during a conversion |

## Verification
On every cycle the assertions check four things. The completion pulse lasts one cycle and falls only while the block is idle. The result register stays frozen outside that pulse. The window select is zero in the first pass and constant inside any pass. A start request during a conversion always leaves the overrun flag set. Only the bench scenarios can show that each nibble lands in its proper field for real codes, and that the midscale neighbours and both end codes resolve exactly. They also show that the completion latency is exactly three settle windows, that a bubble pattern is resolved by counting ones, and that both sticky flags clear on the next accepted start.

// File: rtl/subrange_pkg.sv
package subrange_pkg;

    localparam int DEF_PASSES = 3;
    localparam int DEF_BPP    = 4;
    localparam int DEF_SETTLE = 4;

    // Width of a counter or index that must hold values 0 .. n-1.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/subrange_therm_dec.sv
module subrange_therm_dec #(
    parameter int BPP  = subrange_pkg::DEF_BPP,
    parameter int NCMP = (1 << BPP) - 1
) (
    input  logic [NCMP-1:0] therm_i,
    output logic [BPP-1:0]  count_o,
    output logic            bubble_o
);

    logic [NCMP-2:0] gap;

    // A gap is a set comparator sitting directly above a cleared one.
    for (genvar i = 0; i < NCMP - 1; i++) begin : g_gap
        assign gap[i] = therm_i[i+1] & ~therm_i[i];
    end

    assign bubble_o = |gap;

    always_comb begin
        count_o = '0;
        for (int i = 0; i < NCMP; i++) begin
            count_o = count_o + BPP'(therm_i[i]);
        end
    end

endmodule

// File: rtl/subrange_settle_cnt.sv
module subrange_settle_cnt #(
    parameter int SETTLE = subrange_pkg::DEF_SETTLE,
    parameter int CNT_W  = subrange_pkg::idx_width(SETTLE)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic last_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign last_o = (cnt_q == CNT_W'(SETTLE - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = last_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/subrange_seq.sv
module subrange_seq #(
    parameter int PASSES = subrange_pkg::DEF_PASSES,
    parameter int BPP    = subrange_pkg::DEF_BPP,
    parameter int SETTLE = subrange_pkg::DEF_SETTLE,
    parameter int NCMP   = (1 << BPP) - 1,
    parameter int SEG_W  = (PASSES - 1) * BPP,
    parameter int RES_W  = PASSES * BPP,
    parameter int PASS_W = subrange_pkg::idx_width(PASSES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [NCMP-1:0]   cmp_i,
    output logic [SEG_W-1:0]  seg_sel_o,
    output logic [PASS_W-1:0] pass_o,
    output logic              done_o,
    output logic [RES_W-1:0]  result_o,
    output logic              bubble_err_o,
    output logic              overrun_o
);

    localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(PASSES - 1);

    typedef struct packed {
        logic              busy;
        logic [PASS_W-1:0] pass;
        logic [SEG_W-1:0]  acc;
        logic [RES_W-1:0]  result;
        logic              done;
        logic              bubble;
        logic              overrun;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic           busy;
    logic           start_ok;
    logic           cnt_last;
    logic           pass_end;
    logic [BPP-1:0] nib;
    logic           nib_bubble;

    assign busy     = st_q.busy;
    assign start_ok = start_i & ~st_q.busy;
    assign pass_end = st_q.busy & cnt_last;

    subrange_settle_cnt #(
        .SETTLE (SETTLE)
    ) i_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_ok),
        .en_i   (st_q.busy),
        .last_o (cnt_last)
    );

    subrange_therm_dec #(
        .BPP  (BPP),
        .NCMP (NCMP)
    ) i_dec (
        .therm_i  (cmp_i),
        .count_o  (nib),
        .bubble_o (nib_bubble)
    );

    always_comb begin
        int sh;
        st_d      = st_q;
        st_d.done = 1'b0;
        sh        = (PASSES - 2 - int'(st_q.pass)) * BPP;
        if (start_ok) begin
            st_d.busy    = 1'b1;
            st_d.pass    = '0;
            st_d.acc     = '0;
            st_d.bubble  = 1'b0;
            st_d.overrun = 1'b0;
        end else if (st_q.busy) begin
            if (start_i) begin
                st_d.overrun = 1'b1;
            end
            if (cnt_last) begin
                if (nib_bubble) begin
                    st_d.bubble = 1'b1;
                end
                if (st_q.pass == LAST_PASS) begin
                    st_d.result = {st_q.acc, nib};
                    st_d.done   = 1'b1;
                    st_d.busy   = 1'b0;
                    st_d.pass   = '0;
                end else begin
                    st_d.acc  = st_q.acc | (SEG_W'(nib) << sh);
                    st_d.pass = st_q.pass + PASS_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_sel_o    = st_q.acc;
    assign pass_o       = st_q.pass;
    assign done_o       = st_q.done;
    assign result_o     = st_q.result;
    assign bubble_err_o = st_q.bubble;
    assign overrun_o    = st_q.overrun;

endmodule

// File: rtl/subrange_seq_chk.sv
module subrange_seq_chk #(
    parameter int PASSES = 3,
    parameter int SEG_W  = 8,
    parameter int RES_W  = 12,
    parameter int PASS_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy,
    input logic              pass_end,
    input logic [SEG_W-1:0]  seg_sel_o,
    input logic [PASS_W-1:0] pass_o,
    input logic              done_o,
    input logic [RES_W-1:0]  result_o,
    input logic              overrun_o
);

    // R2: completion pulse is exactly one cycle wide
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: completion is only reported once the sequencer is idle again
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);

    // R7: result register frozen outside the completion pulse
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R3: first pass uses the full-span window
    p_seg_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pass_o == '0) |-> (seg_sel_o == '0));

    // R3: window select constant inside a pass
    p_seg_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pass_end) |=> $stable(seg_sel_o));

    // R3: pass index stays in range
    p_pass_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pass_o) < PASSES);

    // R9: a request during a conversion leaves the overrun flag set
    p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_i) |=> overrun_o);

endmodule

bind subrange_seq subrange_seq_chk #(
    .PASSES (PASSES),
    .SEG_W  (SEG_W),
    .RES_W  (RES_W),
    .PASS_W (PASS_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy      (busy),
    .pass_end  (pass_end),
    .seg_sel_o (seg_sel_o),
    .pass_o    (pass_o),
    .done_o    (done_o),
    .result_o  (result_o),
    .overrun_o (overrun_o)
);

// File: tb/test_subrange_seq.sv
`timescale 1ns/1ps
module test_subrange_seq;

    localparam int PASSES = 3;
    localparam int BPP    = 4;
    localparam int SETTLE = 4;
    localparam int NCMP   = 15;
    localparam int LAT    = PASSES * SETTLE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [14:0] cmp;
    logic [7:0]  seg_sel;
    logic [1:0]  pass;
    logic        done;
    logic [11:0] result;
    logic        bubble;
    logic        overrun;

    logic [11:0] code_r = '0;
    logic        inj_en = 1'b0;
    logic [14:0] inj_pat = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    subrange_seq #(
        .PASSES (PASSES),
        .BPP    (BPP),
        .SETTLE (SETTLE)
    ) i_subrange_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .cmp_i        (cmp),
        .seg_sel_o    (seg_sel),
        .pass_o       (pass),
        .done_o       (done),
        .result_o     (result),
        .bubble_err_o (bubble),
        .overrun_o    (overrun)
    );

    // Ideal comparator bank: threshold k of the window chosen by seg_sel/pass.
    always_comb begin
        int base;
        int step;
        base = int'(seg_sel) << BPP;
        step = 1 << (BPP * (PASSES - 1 - int'(pass)));
        for (int k = 1; k <= NCMP; k++) begin
            cmp[k-1] = (int'(code_r) >= base + k * step);
        end
        if (inj_en) cmp = inj_pat;
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic run_conv(input logic [11:0] code, input bit inject,
                            input bit hit_overrun, output logic [11:0] res);
        logic [11:0] prev;
        int  n;
        bit  seen;
        code_r = code;
        inj_en = inject;
        prev   = result;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 1;
        seen = 0;
        while (!seen && n <= LAT + 4) begin
            if (hit_overrun && n == 5) start = 1'b1;
            if (n == 6) start = 1'b0;
            if (!inject) begin
                if (n == 2) begin
                    chk(pass == 2'd0, "R3 pass index in pass 0", pass, 0);
                    chk(seg_sel == 8'h00, "R3 window in pass 0", seg_sel, 0);
                end
                if (n == 6) begin
                    chk(pass == 2'd1, "R3 pass index in pass 1", pass, 1);
                    chk(seg_sel == {code[11:8], 4'h0}, "R3 window in pass 1",
                        seg_sel, {code[11:8], 4'h0});
                end
                if (n == 10) begin
                    chk(pass == 2'd2, "R3 pass index in pass 2", pass, 2);
                    chk(seg_sel == code[11:4], "R3 window in pass 2", seg_sel, code[11:4]);
                end
            end
            if (n == 6) chk(result == prev, "R7 result held mid-conversion", result, prev);
            if (done) begin
                seen = 1;
                chk(n == LAT + 1, "R2 completion latency in edges", n - 1, LAT);
            end else begin
                @(negedge clk);
                n++;
            end
        end
        chk(seen, "R2 completion pulse seen", seen, 1);
        res = result;
        @(negedge clk);
        chk(!done, "R2 completion pulse one cycle", done, 0);
        repeat (3) @(negedge clk);
        chk(result == res, "R7 result held after completion", result, res);
        inj_en = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({done, result, pass, seg_sel, bubble, overrun} == '0,
            "R1 outputs in reset", {done, result, pass, seg_sel, bubble, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({done, result, pass, seg_sel, bubble, overrun} == '0,
            "R1 outputs after reset", {done, result, pass, seg_sel, bubble, overrun}, 0);
    endtask

    task automatic t_codes;
        logic [11:0] codes [4] = '{12'h123, 12'hA5C, 12'h000, 12'hFFF};
        logic [11:0] r;
        foreach (codes[i]) begin
            run_conv(codes[i], 0, 0, r);
            chk(r == codes[i], "R4 R5 natural binary result", r, codes[i]);
            chk(!bubble && !overrun, "R5 clean conversion flags", {bubble, overrun}, 0);
        end
    endtask

    task automatic t_midscale;
        logic [11:0] r;
        run_conv(12'h7FF, 0, 0, r);
        chk(r == 12'h7FF, "R6 code below midscale", r, 12'h7FF);
        run_conv(12'h800, 0, 0, r);
        chk(r == 12'h800, "R6 code above midscale", r, 12'h800);
    endtask

    task automatic t_bubble;
        logic [11:0] r;
        inj_pat = 15'h0057;   // five set bits with gaps
        run_conv(12'h3C3, 1, 0, r);
        chk(r == 12'h555, "R8 bubble resolved by count", r, 12'h555);
        chk(bubble, "R8 bubble flag set", bubble, 1);
        run_conv(12'h3C3, 0, 0, r);
        chk(!bubble, "R8 bubble flag cleared by next start", bubble, 0);
        chk(r == 12'h3C3, "R8 clean result after bubble", r, 12'h3C3);
    endtask

    task automatic t_overrun;
        logic [11:0] r;
        run_conv(12'h6E9, 0, 1, r);
        chk(r == 12'h6E9, "R9 result unaffected by early request", r, 12'h6E9);
        chk(overrun, "R9 overrun flag set", overrun, 1);
        run_conv(12'h0F1, 0, 0, r);
        chk(!overrun, "R9 overrun flag cleared by next start", overrun, 0);
        chk(r == 12'h0F1, "R9 next result", r, 12'h0F1);
    endtask

    initial begin
        t_reset();
        t_codes();
        t_midscale();
        t_bubble();
        t_overrun();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule